// File: doc/BRIEF.md
# Buffered compare PWM timer channel

This block is a single timer channel built around a free-running up-counter and three compare pairs, labelled A, B and E. Each pair has an active compare register, which the counter is compared against, and a buffer register, which software fills with the next value. Active register A sets the period: when the counter equals it, the counter returns to zero on the next clock. Active register B sets the duty: the PWM pin rises on each counter clear and falls after the counter equals B.

With PWM mode and buffering both enabled for a pair, hardware copies the buffer into the active register at a moment that software chooses for each pair. The copy happens either on that pair's own compare match or on counter clear. A copy takes place in the same clock as the event that triggers it. The comparison made in that clock still uses the old value, so the pulse in progress is not cut short.

A parameter selects the channel variant. Only the full variant has pair E and its timing-select bit. A simple synchronous write port and a combinational read port give software access to every register.

Top module: `pbt_timer`

## Requirements
- R1: The timing-select register at address 1 holds bit 0 for pair A, bit 1 for pair B and bit 2 for pair E. Bits above bit 2 always read as 0, whatever value is written.
- R2: While the run bit (mode register at address 0, bit 0) is 1, the counter (readable at address 8) increments by one each clock. In the clock after it equals active A (address 2), it becomes 0. While the run bit is 0, the counter holds its value.
- R3: While PWM mode (mode bit 1) is 1, pwm_out becomes 1 in the clock after a counter clear and 0 in the clock after the counter equals active B (address 3). Clear wins over a B match. While PWM mode is 0, pwm_out is 0.
- R4: For pair A, timing bit 0 equal to 0 copies buffer C (address 4) into active A on compare match A. A value of 1 copies it on counter clear.
- R5: For pair B, timing bit 1 equal to 0 copies buffer D (address 5) into active B on compare match B. A value of 1 copies it only on counter clear, and never on a B match.
- R6: For pair E, buffer F (address 7) moves into active E (address 6) under the same rule as the other pairs, selected by timing bit 2 and mode bit 4. With HAS_PAIR_E = 0, the E and F registers, timing bit 2 and mode bit 4 read as 0 and ignore writes.
- R7: A copy happens only while PWM mode is 1 and the pair's buffer-enable bit is 1. Those bits are mode bit 2 for A, bit 3 for B and bit 4 for E.
- R8: The comparison made in the clock of a copy uses the old active value. The new value first affects the next clock's comparison.
- R9: When a buffer write falls in the same clock as a copy from that buffer, the old buffer value moves to the active register and the written value stays in the buffer. A write to the active register in that clock is overridden by the copy.
- R10: When buffering is off for a pair, a write to its active register takes effect on the next clock. Its buffer register then acts as an ordinary compare register with its own flag.
- R11: cmp_flag bit i is 1 while the run bit is 1 and the counter equals register i. The bit order, from bit 0, is A, B, C, D, E, F. cnt_clr equals the A flag.
- R12: After reset, every register, the counter and pwm_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | W | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | W | Read data (combinational) |
| cnt | output | W | Counter value |
| cmp_flag | output | 6 | Raw compare-match flags A, B, C, D, E, F |
| cnt_clr | output | 1 | Counter clear source (match A) |
| pwm_out | output | 1 | PWM output |

## Verification
The channel is first run with buffering off. This shows the period and duty behaviour, a run-bit pause and direct writes to the active registers apart from any copy effect. Buffered runs follow, first with copy-on-match and then with copy-on-clear for pair B. Reading B between its match and the next clear tells the two timings apart. A buffer write placed in the exact clock of a clear-triggered copy separates "old value copied" from "new value copied". Runs with PWM mode or buffer enable cleared, and a reduced variant instance, show that copies and the E pair are suppressed.

// File: rtl/pbt_pkg.sv
package pbt_pkg;
    localparam int unsigned ADDR_W    = 4;
    localparam int unsigned MODE_W    = 5;
    localparam int unsigned NPAIR_MAX = 3;
    localparam int unsigned NFLAG     = 2 * NPAIR_MAX;

    localparam int unsigned MODE_RUN  = 0;
    localparam int unsigned MODE_PWM  = 1;
    localparam int unsigned MODE_BUF0 = 2;

    localparam logic [ADDR_W-1:0] ADDR_MODE = 4'd0;
    localparam logic [ADDR_W-1:0] ADDR_TSEL = 4'd1;
    localparam logic [ADDR_W-1:0] ADDR_CNT  = 4'd8;

    // Active register address of pair i (0:A, 1:B, 2:E)
    function automatic logic [ADDR_W-1:0] act_addr(input int i);
        return (i == 2) ? 4'd6 : 4'(2 + i);
    endfunction

    // Buffer register address of pair i (0:C, 1:D, 2:F)
    function automatic logic [ADDR_W-1:0] buf_addr(input int i);
        return (i == 2) ? 4'd7 : 4'(4 + i);
    endfunction
endpackage

// File: rtl/pbt_pair.sv
module pbt_pair #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] cnt,
    input  logic         xfer_en,
    input  logic         tsel,
    input  logic         clr,
    input  logic         wr_act,
    input  logic         wr_buf,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] act,
    output logic [W-1:0] buff,
    output logic         match_act,
    output logic         match_buf
);
    typedef struct packed {
        logic [W-1:0] act;
        logic [W-1:0] buff;
    } pair_t;

    pair_t s_q, s_d;
    logic  xfer;

    assign match_act = run && (cnt == s_q.act);
    assign match_buf = run && (cnt == s_q.buff);
    assign act       = s_q.act;
    assign buff      = s_q.buff;

    always_comb begin
        s_d  = s_q;
        xfer = xfer_en && (tsel ? clr : match_act);
        if (wr_act) s_d.act = wr_data;
        if (xfer)   s_d.act = s_q.buff;
        if (wr_buf) s_d.buff = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4 R5 R6: a copy moves the buffer value into the active register
    a_r5_copy_moves_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> (s_q.act == $past(s_q.buff)));

    // R7: without copy permission and without a write, the active value holds
    a_r7_no_copy_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_en && !wr_act) |=> $stable(s_q.act));

    // R9: a buffer write colliding with a copy stays in the buffer
    a_r9_write_during_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && wr_buf) |=> (s_q.buff == $past(wr_data)));
endmodule

// File: rtl/pbt_counter.sv
module pbt_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         pwm_mode,
    input  logic         clr,
    input  logic         duty_match,
    output logic [W-1:0] cnt,
    output logic         pwm
);
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         pwm;
    } ctr_t;

    ctr_t s_q, s_d;

    assign cnt = s_q.cnt;
    assign pwm = s_q.pwm;

    always_comb begin
        s_d = s_q;
        if (run) s_d.cnt = clr ? '0 : s_q.cnt + ONE;
        if (!pwm_mode)       s_d.pwm = 1'b0;
        else if (clr)        s_d.pwm = 1'b1;
        else if (duty_match) s_d.pwm = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2: period match returns the counter to zero
    a_r2_clear_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (run && clr) |=> (s_q.cnt == '0));

    // R2: a stopped counter holds
    a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(s_q.cnt));

    // R3: clear raises the output in PWM mode
    a_r3_rise_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode && clr) |=> s_q.pwm);

    // R3: output low outside PWM mode
    a_r3_low_outside_pwm: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_mode |=> !s_q.pwm);
endmodule

// File: rtl/pbt_timer.sv
module pbt_timer
    import pbt_pkg::*;
#(
    parameter int unsigned W          = 16,
    parameter bit          HAS_PAIR_E = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data,
    output logic [W-1:0]      cnt,
    output logic [NFLAG-1:0]  cmp_flag,
    output logic              cnt_clr,
    output logic              pwm_out
);
    localparam int unsigned       NPAIR     = HAS_PAIR_E ? 3 : 2;
    localparam logic [MODE_W-1:0] MODE_MASK = HAS_PAIR_E ? 5'h1F : 5'h0F;
    localparam logic [2:0]        TSEL_MASK = HAS_PAIR_E ? 3'b111 : 3'b011;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [2:0]        tsel;
    } cfg_t;

    cfg_t c_q, c_d;

    logic [W-1:0] act_w [NPAIR_MAX];
    logic [W-1:0] buf_w [NPAIR_MAX];
    logic [NPAIR_MAX-1:0] m_act, m_buf;
    logic [W-1:0] cnt_w;
    logic run_w, clr_w, pwm_w;

    assign run_w = c_q.mode[MODE_RUN];
    assign clr_w = m_act[0];

    always_comb begin
        c_d = c_q;
        if (wr_en && wr_addr == ADDR_MODE) c_d.mode = wr_data[MODE_W-1:0] & MODE_MASK;
        if (wr_en && wr_addr == ADDR_TSEL) c_d.tsel = wr_data[2:0] & TSEL_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    for (genvar g = 0; g < NPAIR_MAX; g++) begin : g_pair
        if (g < NPAIR) begin : g_on
            pbt_pair #(.W(W)) u_pair (
                .clk       (clk),
                .rst_n     (rst_n),
                .run       (run_w),
                .cnt       (cnt_w),
                .xfer_en   (c_q.mode[MODE_PWM] && c_q.mode[MODE_BUF0 + g]),
                .tsel      (c_q.tsel[g]),
                .clr       (clr_w),
                .wr_act    (wr_en && (wr_addr == act_addr(g))),
                .wr_buf    (wr_en && (wr_addr == buf_addr(g))),
                .wr_data   (wr_data),
                .act       (act_w[g]),
                .buff      (buf_w[g]),
                .match_act (m_act[g]),
                .match_buf (m_buf[g])
            );
        end else begin : g_off
            assign act_w[g] = '0;
            assign buf_w[g] = '0;
            assign m_act[g] = 1'b0;
            assign m_buf[g] = 1'b0;
        end
    end

    pbt_counter #(.W(W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run_w),
        .pwm_mode   (c_q.mode[MODE_PWM]),
        .clr        (clr_w),
        .duty_match (m_act[1]),
        .cnt        (cnt_w),
        .pwm        (pwm_w)
    );

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NPAIR_MAX; i++) begin
            if (rd_addr == act_addr(i)) rd_data = act_w[i];
            if (rd_addr == buf_addr(i)) rd_data = buf_w[i];
        end
        case (rd_addr)
            ADDR_MODE: rd_data[MODE_W-1:0] = c_q.mode;
            ADDR_TSEL: rd_data[2:0]        = c_q.tsel;
            ADDR_CNT:  rd_data             = cnt_w;
            default:   ;
        endcase
    end

    assign cnt      = cnt_w;
    assign cnt_clr  = clr_w;
    assign pwm_out  = pwm_w;
    assign cmp_flag = {m_buf[2], m_act[2], m_buf[1], m_buf[0], m_act[1], m_act[0]};

    // R1: reserved timing bits never read back as 1
    a_r1_reserved_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_TSEL) |-> ((rd_data >> 3) == '0));

    // R11: a period flag is followed by a zero counter
    a_r11_clear_flag_zeroes_count: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_flag[0] |=> (cnt == '0));
endmodule

// File: tb/tb_pbt_timer.sv
`timescale 1ns/1ps
module tb_pbt_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data, rd_data_ne, cnt, cnt_ne;
    logic [5:0]  cmp_flag, cmp_flag_ne;
    logic        cnt_clr, cnt_clr_ne, pwm_out, pwm_out_ne;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pbt_timer #(.W(16), .HAS_PAIR_E(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cnt(cnt), .cmp_flag(cmp_flag),
        .cnt_clr(cnt_clr), .pwm_out(pwm_out));

    pbt_timer #(.W(16), .HAS_PAIR_E(1'b0)) dut_ne (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data_ne), .cnt(cnt_ne), .cmp_flag(cmp_flag_ne),
        .cnt_clr(cnt_clr_ne), .pwm_out(pwm_out_ne));

    typedef struct {
        logic [15:0] cnt;
        logic        pwm;
        logic [5:0]  flg;
    } item_t;
    item_t sb[$];

    function automatic logic [3:0] a_of(int i); return (i == 2) ? 4'd6 : 4'(2 + i); endfunction
    function automatic logic [3:0] b_of(int i); return (i == 2) ? 4'd7 : 4'(4 + i); endfunction

    // Reference model built from the requirements; drives the scoreboard
    logic [15:0] m_cnt, m_act[3], m_buf[3];
    logic [4:0]  m_mode;
    logic [2:0]  m_tsel;
    logic        m_pwm;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_pwm = 0; m_mode = 0; m_tsel = 0;
            for (int i = 0; i < 3; i++) begin m_act[i] = 0; m_buf[i] = 0; end
        end else begin
            logic run, pm, clr;
            logic [2:0] ma, xf;
            logic [15:0] na[3], nb[3];
            item_t it;
            run = m_mode[0]; pm = m_mode[1];
            for (int i = 0; i < 3; i++) ma[i] = run && (m_cnt == m_act[i]);
            clr = ma[0];
            for (int i = 0; i < 3; i++) begin
                xf[i] = pm && m_mode[2+i] && (m_tsel[i] ? clr : ma[i]);
                na[i] = m_act[i]; nb[i] = m_buf[i];
                if (wr_en && wr_addr == a_of(i)) na[i] = wr_data;
                if (xf[i]) na[i] = m_buf[i];
                if (wr_en && wr_addr == b_of(i)) nb[i] = wr_data;
            end
            if (run) m_cnt = clr ? 16'd0 : m_cnt + 16'd1;
            if (!pm) m_pwm = 0; else if (clr) m_pwm = 1; else if (ma[1]) m_pwm = 0;
            for (int i = 0; i < 3; i++) begin m_act[i] = na[i]; m_buf[i] = nb[i]; end
            if (wr_en && wr_addr == 4'd0) m_mode = wr_data[4:0];
            if (wr_en && wr_addr == 4'd1) m_tsel = wr_data[2:0];
            it.cnt = m_cnt;
            it.pwm = m_pwm;
            it.flg[0] = m_mode[0] && (m_cnt == m_act[0]);
            it.flg[1] = m_mode[0] && (m_cnt == m_act[1]);
            it.flg[2] = m_mode[0] && (m_cnt == m_buf[0]);
            it.flg[3] = m_mode[0] && (m_cnt == m_buf[1]);
            it.flg[4] = m_mode[0] && (m_cnt == m_act[2]);
            it.flg[5] = m_mode[0] && (m_cnt == m_buf[2]);
            sb.push_back(it);
        end
    end

    // Monitor: compares each cycle's outputs with the expected item
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t e;
            e = sb.pop_front();
            checks++;
            if (cnt !== e.cnt) begin errors++;
                $display("FAIL R2 counter: actual %0d expected %0d", cnt, e.cnt); end
            checks++;
            if (pwm_out !== e.pwm) begin errors++;
                $display("FAIL R3 R8 pwm_out: actual %0b expected %0b", pwm_out, e.pwm); end
            checks++;
            if (cmp_flag !== e.flg) begin errors++;
                $display("FAIL R11 cmp_flag: actual %b expected %b", cmp_flag, e.flg); end
            checks++;
            if (cnt_clr !== e.flg[0]) begin errors++;
                $display("FAIL R11 cnt_clr: actual %0b expected %0b", cnt_clr, e.flg[0]); end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
        rd_addr = a; #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic rd_ne(input logic [3:0] a, input logic [15:0] exp, input string tag);
        rd_addr = a; #1;
        chk(tag, rd_data_ne, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_cnt(input logic [15:0] v);
        do @(negedge clk); while (cnt != v);
    endtask

    initial begin
        logic [15:0] held;
        idle(3);
        rst_n = 1'b1;
        // R12: reset state
        for (int a = 0; a < 9; a++) rd(4'(a), 16'd0, "R12 reset register");
        chk("R12 reset pwm_out", {15'd0, pwm_out}, 16'd0);
        chk("R12 reset cnt", cnt, 16'd0);

        // R1 and R6: reserved and variant-dependent timing bits
        wr(4'd1, 16'hFFFF);
        rd(4'd1, 16'h0007, "R1 timing readback");
        rd_ne(4'd1, 16'h0003, "R6 reduced variant timing bit 2");
        wr(4'd1, 16'h0000);
        rd(4'd1, 16'h0000, "R1 timing cleared");

        // R2 R3: plain PWM, period 10, duty up to 3
        wr(4'd2, 16'd9); wr(4'd3, 16'd3); wr(4'd0, 16'h0003);
        idle(30);
        wait_cnt(16'd2);
        chk("R3 pwm high before duty match", {15'd0, pwm_out}, 16'd1);
        wait_cnt(16'd5);
        chk("R3 pwm low after duty match", {15'd0, pwm_out}, 16'd0);

        // R2: stopping the counter holds it
        wr(4'd0, 16'h0002);
        held = cnt;
        idle(5);
        chk("R2 counter holds when stopped", cnt, held);
        wr(4'd0, 16'h0003);

        // R4 R5: copy on own compare match
        wr(4'd4, 16'd5); wr(4'd5, 16'd1);
        wr(4'd0, 16'h000F);
        idle(25);
        rd(4'd3, 16'd1, "R5 B copied on match");
        rd(4'd2, 16'd5, "R4 A copied on match");

        // R5: copy on clear, not on match
        wr(4'd1, 16'h0002);
        wait_cnt(16'd1);
        wr(4'd5, 16'd4);
        rd(4'd3, 16'd1, "R5 B not copied at match with clear timing");
        wait_cnt(16'd1);
        rd(4'd3, 16'd4, "R5 B copied at clear");

        // R9: buffer write in the copy clock
        wait_cnt(16'd5);
        wr(4'd5, 16'd7);
        rd(4'd3, 16'd4, "R9 old buffer value copied");
        rd(4'd5, 16'd7, "R9 new value kept in buffer");
        wait_cnt(16'd4);
        wait_cnt(16'd1);
        rd(4'd3, 16'd7, "R9 kept value copied at next clear");

        // R7: no copy without buffer enable, nor without PWM mode
        wr(4'd1, 16'h0000);
        wr(4'd0, 16'h0003);
        wr(4'd4, 16'd3);
        idle(20);
        rd(4'd2, 16'd5, "R7 no copy with buffering off");
        wr(4'd0, 16'h000D);
        wr(4'd5, 16'd2);
        idle(20);
        rd(4'd3, 16'd7, "R7 no copy with PWM mode off");
        chk("R3 pwm low outside PWM mode", {15'd0, pwm_out}, 16'd0);

        // R10 R11: direct writes and buffer register as plain compare
        wr(4'd0, 16'h0003);
        wr(4'd2, 16'd8);
        rd(4'd2, 16'd8, "R10 direct active write");
        wait_cnt(16'd3);
        chk("R10 buffer C flags as plain compare", {10'd0, cmp_flag}, 16'h0004);
        wait_cnt(16'd8);
        chk("R11 period flag alone", {10'd0, cmp_flag}, 16'h0001);

        // R6: pair E copy in the full variant, absent in the reduced one
        wr(4'd0, 16'h0013);
        wr(4'd7, 16'd6);
        wr(4'd6, 16'd2);
        idle(20);
        rd(4'd6, 16'd6, "R6 E copied from F");
        rd_ne(4'd6, 16'd0, "R6 reduced variant E reads zero");
        rd_ne(4'd7, 16'd0, "R6 reduced variant F reads zero");
        rd_ne(4'd0, 16'h0003, "R6 reduced variant mode bit 4 dropped");

        idle(4);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule